// File: doc/BRIEF.md
# Branch target buffer

This block sits beside the fetch stage and turns the current fetch address into the address of the next fetch. It is a direct-mapped table: a few low bits of the instruction address, above the byte offset, select one entry. The rest of the address is compared in full against that entry's stored tag. Each entry keeps a valid bit, the tag, a full predicted target address and a 2-bit saturating direction counter.

The lookup is combinational within the fetch cycle. When the entry matches and its counter predicts taken, fetch is redirected to the stored target. In every other case fetch continues at the fetch address plus 4.

A separate update port carries resolved branches from later in the pipeline, one per cycle. An update is written on the clock edge, so it is only seen by lookups in later cycles. A taken branch that misses claims its entry, evicting whatever was there. A not-taken branch that misses leaves the table alone. A branch that hits trains the counter, and when it is taken it also corrects the stored target.

Top module: `fetch_target_buffer`

## Requirements
- R1: After reset every entry is invalid: every lookup reports no hit, no taken prediction, and next address = fetch address + 4.
- R2: On a lookup miss (invalid entry or tag mismatch), nextPc = fetchPc + 4 and predTaken = 0.
- R3: A resolved taken update that misses writes the entry with its tag and target and sets the counter to weakly taken (binary 10). From the next cycle, a lookup of that address hits, predicts taken and returns the target. A single not-taken update then makes it predict not taken.
- R4: A resolved not-taken update that misses writes nothing: a later lookup of that address still misses.
- R5: On an update hit, the counter moves one step toward the outcome (up when taken, down when not taken). The prediction is the counter's upper bit: binary 10 and 11 mean taken, 00 and 01 mean not taken.
- R6: From strongly taken (11), one not-taken update leaves the prediction taken.
- R7: A lookup that hits with the counter at 00 or 01 reports predHit = 1 and predTaken = 0, and gives nextPc = fetchPc + 4.
- R8: Index is fetch address bits [IDX_W+1:2], and the tag is all bits above that. Two addresses with the same index but different tags never hit on each other's entry. A taken update of the second replaces the first, which then misses.
- R9: A taken update that hits with a different target rewrites the stored target, and later lookups return the new target.
- R10: An update is visible to lookups only from the cycle after its clock edge. A lookup in the same cycle as the update sees the old table contents.
- R11: The counter saturates. Not-taken at 00 stays 00, and from 00 it takes two taken updates before the prediction becomes taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low; clears all valid bits |
| fetchPc | input | PC_W | Address being fetched this cycle |
| nextPc | output | PC_W | Address to fetch next |
| predHit | output | 1 | Lookup matched a valid entry |
| predTaken | output | 1 | Lookup matched and the counter predicts taken |
| predTarget | output | PC_W | Stored target of the matching entry |
| updValid | input | 1 | A resolved branch is presented this cycle |
| updPc | input | PC_W | Address of the resolved branch |
| updTaken | input | 1 | Resolved direction, 1 = taken |
| updTarget | input | PC_W | Resolved target address |

## Verification
The assertions assume that only one resolved branch is presented per cycle, and that updPc, updTaken and updTarget are stable while updValid is high around the clock edge. They also assume that fetch addresses and update addresses are word aligned. The bench drives every input on the falling edge, holds each update for exactly one rising edge, and uses only word-aligned addresses. It chooses these addresses so that aliasing occurs only where a scenario wants it.

// File: rtl/ftb_pkg.sv
package ftb_pkg;

  localparam logic [1:0] CTR_STRONG_NT  = 2'b00;
  localparam logic [1:0] CTR_WEAK_TAKEN = 2'b10;
  localparam logic [1:0] CTR_STRONG_T   = 2'b11;

  typedef struct packed {
    logic       alloc;     // claim the entry for a taken miss
    logic       train;     // update-hit: write the new counter value
    logic       retarget;  // update-hit, taken, target differs
    logic [1:0] newCtr;    // counter value to write
  } ftbWrStrobe_t;

  function automatic logic [1:0] ctrStep(input logic [1:0] cur, input logic up);
    logic [1:0] res;
    if (up) res = (cur == CTR_STRONG_T)  ? cur : cur + 2'd1;
    else    res = (cur == CTR_STRONG_NT) ? cur : cur - 2'd1;
    return res;
  endfunction

endpackage

// File: rtl/ftb_datapath.sv
module ftb_datapath
  import ftb_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PC_W-1:0]  fetchPc,
  input  logic [PC_W-1:0]  updPc,
  input  logic [PC_W-1:0]  updTarget,
  input  ftbWrStrobe_t     strobe,
  output logic             lkHit,
  output logic [1:0]       lkCtr,
  output logic [PC_W-1:0]  lkTarget,
  output logic             upHit,
  output logic [1:0]       upCtr,
  output logic             upTargetSame
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int IDX_LO = 2;
  localparam int TAG_LO = IDX_LO + IDX_W;
  localparam int TAG_W  = PC_W - TAG_LO;

  logic [ENTRIES-1:0] validQ;
  logic [TAG_W-1:0]   tagQ    [ENTRIES];
  logic [PC_W-1:0]    targetQ [ENTRIES];
  logic [1:0]         ctrQ    [ENTRIES];

  logic [IDX_W-1:0] lkIdx, upIdx;
  logic [TAG_W-1:0] lkTag, upTag;

  assign lkIdx = fetchPc[TAG_LO-1:IDX_LO];
  assign lkTag = fetchPc[PC_W-1:TAG_LO];
  assign upIdx = updPc[TAG_LO-1:IDX_LO];
  assign upTag = updPc[PC_W-1:TAG_LO];

  // lookup port
  assign lkHit    = validQ[lkIdx] && (tagQ[lkIdx] == lkTag);
  assign lkCtr    = ctrQ[lkIdx];
  assign lkTarget = targetQ[lkIdx];

  // update-side read port
  assign upHit        = validQ[upIdx] && (tagQ[upIdx] == upTag);
  assign upCtr        = ctrQ[upIdx];
  assign upTargetSame = (targetQ[upIdx] == updTarget);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validQ <= '0;
    else if (strobe.alloc) validQ[upIdx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strobe.alloc) tagQ[upIdx] <= upTag;
    if (strobe.alloc || strobe.retarget) targetQ[upIdx] <= updTarget;
    if (strobe.alloc || strobe.train) ctrQ[upIdx] <= strobe.newCtr;
  end

  // R3: an allocation leaves a valid, weakly-taken entry holding the target
  assert_alloc_fills_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.alloc |=> (validQ[$past(upIdx)] &&
                      targetQ[$past(upIdx)] == $past(updTarget) &&
                      ctrQ[$past(upIdx)] == CTR_WEAK_TAKEN));

  // R4: a cycle with neither allocation nor training keeps every valid bit
  assert_valid_kept_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.alloc && !strobe.train) |=> $stable(validQ));

  // R5/R11: training moves the counter by at most one step and never wraps
  assert_ctr_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.train && !strobe.alloc) |=>
      ((ctrQ[$past(upIdx)] == $past(upCtr)) ||
       (ctrQ[$past(upIdx)] == $past(upCtr) + 2'd1 && $past(upCtr) != 2'b11) ||
       (ctrQ[$past(upIdx)] == $past(upCtr) - 2'd1 && $past(upCtr) != 2'b00)));

endmodule

// File: rtl/ftb_ctrl.sv
module ftb_ctrl
  import ftb_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PC_W-1:0]  fetchPc,
  input  logic             updValid,
  input  logic             updTaken,
  input  logic             lkHit,
  input  logic [1:0]       lkCtr,
  input  logic [PC_W-1:0]  lkTarget,
  input  logic             upHit,
  input  logic [1:0]       upCtr,
  input  logic             upTargetSame,
  output ftbWrStrobe_t     strobe,
  output logic             predHit,
  output logic             predTaken,
  output logic [PC_W-1:0]  predTarget,
  output logic [PC_W-1:0]  nextPc
);

  localparam logic [PC_W-1:0] INSN_BYTES = PC_W'(4);

  logic [PC_W-1:0] seqPc;

  assign seqPc = fetchPc + INSN_BYTES;

  always_comb begin
    predHit    = lkHit;
    predTaken  = lkHit && lkCtr[1];
    predTarget = lkTarget;
    nextPc     = predTaken ? lkTarget : seqPc;
  end

  always_comb begin
    strobe          = '0;
    strobe.alloc    = updValid && updTaken && !upHit;
    strobe.train    = updValid && upHit;
    strobe.retarget = updValid && upHit && updTaken && !upTargetSame;
    strobe.newCtr   = strobe.alloc ? CTR_WEAK_TAKEN : ctrStep(upCtr, updTaken);
  end

  // R4: a not-taken resolution never claims an entry
  assert_nt_never_allocs_R4: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && !updTaken) |-> !strobe.alloc);

endmodule

// File: rtl/fetch_target_buffer.sv
module fetch_target_buffer
  import ftb_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PC_W-1:0]  fetchPc,
  output logic [PC_W-1:0]  nextPc,
  output logic             predHit,
  output logic             predTaken,
  output logic [PC_W-1:0]  predTarget,
  input  logic             updValid,
  input  logic [PC_W-1:0]  updPc,
  input  logic             updTaken,
  input  logic [PC_W-1:0]  updTarget
);

  ftbWrStrobe_t    strobe;
  logic            lkHit, upHit, upTargetSame;
  logic [1:0]      lkCtr, upCtr;
  logic [PC_W-1:0] lkTarget;

  ftb_datapath #(.PC_W(PC_W), .ENTRIES(ENTRIES)) u_dp (
    .clk(clk), .rstN(rstN), .fetchPc(fetchPc), .updPc(updPc),
    .updTarget(updTarget), .strobe(strobe), .lkHit(lkHit), .lkCtr(lkCtr),
    .lkTarget(lkTarget), .upHit(upHit), .upCtr(upCtr),
    .upTargetSame(upTargetSame)
  );

  ftb_ctrl #(.PC_W(PC_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .fetchPc(fetchPc), .updValid(updValid),
    .updTaken(updTaken), .lkHit(lkHit), .lkCtr(lkCtr), .lkTarget(lkTarget),
    .upHit(upHit), .upCtr(upCtr), .upTargetSame(upTargetSame),
    .strobe(strobe), .predHit(predHit), .predTaken(predTaken),
    .predTarget(predTarget), .nextPc(nextPc)
  );

  // R2/R7: without a taken prediction fetch stays sequential
  assert_seq_fallthrough_R2: assert property (@(posedge clk) disable iff (!rstN)
    !predTaken |-> nextPc == fetchPc + PC_W'(4));

  // R3: a taken prediction redirects to the stored target
  assert_redirect_R3: assert property (@(posedge clk) disable iff (!rstN)
    predTaken |-> (predHit && nextPc == predTarget));

endmodule

// File: tb/sim_fetch_target_buffer.sv
`timescale 1ns/1ps
module sim_fetch_target_buffer;

  localparam int PC_W = 32;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [PC_W-1:0] fetchPc = '0;
  logic [PC_W-1:0] nextPc;
  logic            predHit, predTaken;
  logic [PC_W-1:0] predTarget;
  logic            updValid = 1'b0;
  logic [PC_W-1:0] updPc = '0;
  logic            updTaken = 1'b0;
  logic [PC_W-1:0] updTarget = '0;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  fetch_target_buffer #(.PC_W(PC_W), .ENTRIES(16)) u0 (
    .clk(clk), .rstN(rstN), .fetchPc(fetchPc), .nextPc(nextPc),
    .predHit(predHit), .predTaken(predTaken), .predTarget(predTarget),
    .updValid(updValid), .updPc(updPc), .updTaken(updTaken),
    .updTarget(updTarget)
  );

  // index = bits [5:2] with 16 entries
  localparam logic [31:0] PC_A = 32'h0000_1040; // index 0
  localparam logic [31:0] PC_B = 32'h0000_2040; // index 0, other tag
  localparam logic [31:0] PC_C = 32'h0000_1044; // index 1
  localparam logic [31:0] PC_D = 32'h0000_1048; // index 2

  task automatic checkVal(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic look(input logic [31:0] pc, input logic expHit,
                      input logic expTaken, input logic [31:0] expNext,
                      input string req);
    @(negedge clk);
    fetchPc = pc;
    #1;
    checkVal(req, "hit",   {31'd0, predHit},   {31'd0, expHit});
    checkVal(req, "taken", {31'd0, predTaken}, {31'd0, expTaken});
    checkVal(req, "next",  nextPc, expNext);
  endtask

  task automatic upd(input logic [31:0] pc, input logic tk, input logic [31:0] tgt);
    @(negedge clk);
    updValid = 1'b1; updPc = pc; updTaken = tk; updTarget = tgt;
    @(negedge clk);
    updValid = 1'b0;
  endtask

  task automatic testReset();
    look(PC_A, 1'b0, 1'b0, PC_A + 4, "R1");
    look(PC_D, 1'b0, 1'b0, PC_D + 4, "R1");
  endtask

  task automatic testNotTakenMiss();
    upd(PC_C, 1'b0, 32'h0000_5000);
    look(PC_C, 1'b0, 1'b0, PC_C + 4, "R4");
    look(PC_C, 1'b0, 1'b0, PC_C + 4, "R2");
  endtask

  task automatic testAllocate();
    upd(PC_A, 1'b1, 32'h0000_3000);
    look(PC_A, 1'b1, 1'b1, 32'h0000_3000, "R3");
    checkVal("R3", "target", predTarget, 32'h0000_3000);
  endtask

  task automatic testSameCycle();
    @(negedge clk);
    updValid = 1'b1; updPc = PC_D; updTaken = 1'b1; updTarget = 32'h0000_7000;
    fetchPc = PC_D;
    #1;
    checkVal("R10", "hit before edge", {31'd0, predHit}, 32'd0);
    checkVal("R10", "next before edge", nextPc, PC_D + 4);
    @(negedge clk);
    updValid = 1'b0;
    #1;
    checkVal("R10", "hit after edge", {31'd0, predHit}, 32'd1);
    checkVal("R10", "next after edge", nextPc, 32'h0000_7000);
  endtask

  task automatic testTraining();
    upd(PC_A, 1'b0, 32'h0);                           // 10 -> 01
    look(PC_A, 1'b1, 1'b0, PC_A + 4, "R7");
    upd(PC_A, 1'b0, 32'h0);                           // 01 -> 00
    upd(PC_A, 1'b0, 32'h0);                           // 00 stays
    upd(PC_A, 1'b1, 32'h0000_3000);                   // 00 -> 01
    look(PC_A, 1'b1, 1'b0, PC_A + 4, "R11");
    upd(PC_A, 1'b1, 32'h0000_3000);                   // 01 -> 10
    look(PC_A, 1'b1, 1'b1, 32'h0000_3000, "R5");
    upd(PC_A, 1'b1, 32'h0000_3000);                   // 10 -> 11
    upd(PC_A, 1'b1, 32'h0000_3000);                   // 11 stays
    upd(PC_A, 1'b0, 32'h0);                           // 11 -> 10
    look(PC_A, 1'b1, 1'b1, 32'h0000_3000, "R6");
    upd(PC_A, 1'b0, 32'h0);                           // 10 -> 01
    look(PC_A, 1'b1, 1'b0, PC_A + 4, "R5");
  endtask

  task automatic testRetarget();
    upd(PC_A, 1'b1, 32'h0000_3800);                   // 01 -> 10, new target
    look(PC_A, 1'b1, 1'b1, 32'h0000_3800, "R9");
  endtask

  task automatic testAlias();
    look(PC_B, 1'b0, 1'b0, PC_B + 4, "R8");
    upd(PC_B, 1'b1, 32'h0000_9000);
    look(PC_B, 1'b1, 1'b1, 32'h0000_9000, "R8");
    look(PC_A, 1'b0, 1'b0, PC_A + 4, "R8");
    look(PC_C, 1'b0, 1'b0, PC_C + 4, "R2");
    upd(PC_B, 1'b0, 32'h0);                           // weak taken -> 01
    look(PC_B, 1'b1, 1'b0, PC_B + 4, "R3");
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #20000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testNotTakenMiss();
    testAllocate();
    testSameCycle();
    testTraining();
    testRetarget();
    testAlias();
    repeat (2) @(negedge clk);
    summary();
  end

endmodule